// File: doc/BRIEF.md
# Reversible Cascade Synthesis Engine

The engine turns a small reversible function, held as a permutation table of 2^n words with n = 3 or 4, into a cascade of multiple-control Toffoli gates. A host writes the table, where entry i holds the output word for input i. The host may also write a row-visit order. It then pulses `start`. The engine visits the rows one at a time, either in natural binary order or in the supplied order. For each row it finds gates that bring the working word to the row's own index, and it applies every gate to the whole table in one cycle.

Each gate leaves the engine as a record on a valid/ready stream. The record holds a control mask and a target bit index. The first record belongs to the output end of the circuit, so the circuit that realizes the function is the list read backwards. A row that is already correct is skipped. Rows that have been corrected earlier in the visit order are never touched again. When all rows are visited the engine raises `done` and reports the number of gates. `error` is raised when the table is not a permutation, when the gate budget of n·2^n would be exceeded, or when the table is not the identity at the end.

Top module: `rev_synth_engine`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `gateValid` are 0 and `gateCount` is 0.
- R2: Bit i of a word is variable i, and bit n-1 is the most significant variable. In a gate record, `gateCtrl` bit i set means bit i is a control, and `gateTarget` is the index of the flipped bit. Applying a gate inverts the target bit of every table word whose control bits are all 1. The target bit is never set in the control mask.
- R3: Rows are corrected one at a time in visit order. Once every row up to some position of the order equals its index, no later gate changes any of those rows.
- R4: For the current row, bits that are 0 in the working word and 1 in the row index are corrected first, lowest index first. Their control mask is the working word's 1 bits minus the target. After that, bits that are 1 in the word and 0 in the index are corrected, lowest index first. Their control mask is the row index.
- R5: A row that already equals its index emits no gate. For n = 3 and the table 0,4,5,1,6,2,3,7 in natural order, the first gate has control mask 3'b100 and target 0. The run ends after 6 gates.
- R6: When the visit ends, `done` is 1 and `busy` is 0. `gateCount` equals the number of accepted gate records, and applying those gates to the loaded table yields the identity. A new start on that table emits no gate.
- R7: While `gateValid` is 1 and `gateReady` is 0, the record stays valid and unchanged, and the table is not updated.
- R8: With `naturalOrder` = 1 the row visit order is 0,1,…,2^n−1, and the stored order is ignored. With `naturalOrder` = 0 the stored order is used, where entry p names the row visited p-th.
- R9: If the loaded table is not a permutation, the engine emits no gate and ends with `done` = 1 and `error` = 1.
- R10: `gateCount` never exceeds n·2^n. If another gate would be needed at that count, the run ends with `error` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| loadEn | input | 1 | Write one table word (ignored while busy) |
| loadAddr | input | N_BITS | Table row written |
| loadWord | input | N_BITS | Output word for that row |
| orderEn | input | 1 | Write one visit-order entry (ignored while busy) |
| orderAddr | input | N_BITS | Visit position written |
| orderRow | input | N_BITS | Row visited at that position |
| naturalOrder | input | 1 | Select binary visit order, sampled at start |
| start | input | 1 | Begin a synthesis run when not busy |
| gateValid | output | 1 | Gate record valid |
| gateReady | input | 1 | Consumer accepts the record |
| gateCtrl | output | N_BITS | Control mask of the gate |
| gateTarget | output | TW | Index of the target bit |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| error | output | 1 | Run ended abnormally |
| gateCount | output | CW | Gates accepted in this run |

## Verification
On every cycle, the checker confirms four things: a stalled gate record holds still, no target is also a control, the gate count rises by exactly one per accepted record and stays inside the budget, and a finished engine emits nothing. Only the bench scenarios can show the remaining behaviour. These are the 0→1-before-1→0 choice of target and controls, the preservation of already corrected rows, and convergence to the identity. The bench replays every accepted gate on its own copy of the table across a sweep of generated permutations, in both binary and popcount-banded visit orders. The worked example, the identity and non-permutation tables, and the restart after completion are also bench-only scenarios.

// File: rtl/rev_synth_pkg.sv
package rev_synth_pkg;

  // strobes from the sequencer to the table datapath
  typedef struct packed {
    logic clearRun;   // new run: zero the counter, sample the order mode
    logic latchGate;  // capture the next gate for the current row
    logic applyGate;  // record accepted: apply it to every table word
  } rsStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SCAN,
    ST_EMIT,
    ST_DONE
  } rsState_t;

endpackage

// File: rtl/rs_datapath.sv
module rs_datapath
  import rev_synth_pkg::*;
#(
  parameter int N_BITS = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  loadEn,
  input  logic [N_BITS-1:0]                     loadAddr,
  input  logic [N_BITS-1:0]                     loadWord,
  input  logic                                  orderEn,
  input  logic [N_BITS-1:0]                     orderAddr,
  input  logic [N_BITS-1:0]                     orderRow,
  input  logic                                  naturalOrder,
  input  rsStrobe_t                             strobe,
  input  logic [N_BITS-1:0]                     pos,
  output logic                                  rowFixed,
  output logic                                  isPerm,
  output logic                                  isIdentity,
  output logic                                  countAtLimit,
  output logic [N_BITS-1:0]                     gateCtrl,
  output logic [((N_BITS > 1) ? $clog2(N_BITS) : 1)-1:0] gateTarget,
  output logic [$clog2(N_BITS*(1<<N_BITS)+1)-1:0] gateCount
);
  localparam int ROWS  = 1 << N_BITS;
  localparam int TW    = (N_BITS > 1) ? $clog2(N_BITS) : 1;
  localparam int LIMIT = N_BITS * ROWS;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [N_BITS-1:0] tbl [ROWS];
  logic [N_BITS-1:0] ord [ROWS];
  logic              useNatural;

  logic [N_BITS-1:0] rowSel, word, upBits, downBits;
  logic [N_BITS-1:0] tgtMask;
  logic [ROWS-1:0]   seen, idBits;

  function automatic logic [TW-1:0] lowIdx(input logic [N_BITS-1:0] v);
    lowIdx = '0;
    for (int i = N_BITS - 1; i >= 0; i--) if (v[i]) lowIdx = TW'(i);
  endfunction

  // current row and its working word
  assign rowSel   = useNatural ? pos : ord[pos];
  assign word     = tbl[rowSel];
  assign rowFixed = (word == rowSel);
  assign upBits   = rowSel & ~word;
  assign downBits = word & ~rowSel;
  assign tgtMask  = N_BITS'(1) << gateTarget;

  // permutation test over the whole table
  always_comb begin
    seen = '0;
    for (int k = 0; k < ROWS; k++) seen[tbl[k]] = 1'b1;
  end
  assign isPerm = &seen;

  for (genvar g = 0; g < ROWS; g++) begin : g_ident
    assign idBits[g] = (tbl[g] == N_BITS'(g));
  end
  assign isIdentity = &idBits;

  assign countAtLimit = (int'(gateCount) >= LIMIT);

  // working table: load port, or one gate applied to all rows at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ROWS; k++) tbl[k] <= N_BITS'(k);
    end else if (strobe.applyGate) begin
      for (int k = 0; k < ROWS; k++)
        if ((tbl[k] & gateCtrl) == gateCtrl) tbl[k] <= tbl[k] ^ tgtMask;
    end else if (loadEn) begin
      tbl[loadAddr] <= loadWord;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ROWS; k++) ord[k] <= N_BITS'(k);
    end else if (orderEn) begin
      ord[orderAddr] <= orderRow;
    end
  end

  // gate choice: raise missing 1s first, then clear surplus 1s
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gateCtrl   <= '0;
      gateTarget <= '0;
    end else if (strobe.latchGate) begin
      if (upBits != '0) begin
        gateTarget <= lowIdx(upBits);
        gateCtrl   <= word & ~(N_BITS'(1) << lowIdx(upBits));
      end else begin
        gateTarget <= lowIdx(downBits);
        gateCtrl   <= rowSel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gateCount  <= '0;
      useNatural <= 1'b1;
    end else if (strobe.clearRun) begin
      gateCount  <= '0;
      useNatural <= naturalOrder;
    end else if (strobe.applyGate && !countAtLimit) begin
      gateCount <= gateCount + CW'(1);
    end
  end

endmodule

// File: rtl/rs_control.sv
module rs_control
  import rev_synth_pkg::*;
#(
  parameter int N_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              gateReady,
  input  logic              rowFixed,
  input  logic              isPerm,
  input  logic              isIdentity,
  input  logic              countAtLimit,
  output rsStrobe_t         strobe,
  output logic [N_BITS-1:0] pos,
  output logic              gateValid,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam logic [N_BITS-1:0] LAST_POS = '1;

  rsState_t state;

  assign gateValid = (state == ST_EMIT);
  assign busy      = (state == ST_CHECK) || (state == ST_SCAN) || (state == ST_EMIT);
  assign done      = (state == ST_DONE);

  always_comb begin
    strobe           = '0;
    strobe.clearRun  = start && ((state == ST_IDLE) || (state == ST_DONE));
    strobe.latchGate = (state == ST_SCAN) && !rowFixed && !countAtLimit;
    strobe.applyGate = (state == ST_EMIT) && gateReady;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pos   <= '0;
      error <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state <= ST_CHECK;
            error <= 1'b0;
          end
        end
        ST_CHECK: begin
          pos <= '0;
          if (isPerm) state <= ST_SCAN;
          else begin
            error <= 1'b1;
            state <= ST_DONE;
          end
        end
        ST_SCAN: begin
          if (rowFixed) begin
            if (pos == LAST_POS) begin
              error <= !isIdentity;
              state <= ST_DONE;
            end else begin
              pos <= pos + N_BITS'(1);
            end
          end else if (countAtLimit) begin
            error <= 1'b1;
            state <= ST_DONE;
          end else begin
            state <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (gateReady) state <= ST_SCAN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rev_synth_engine.sv
module rev_synth_engine
  import rev_synth_pkg::*;
#(
  parameter int N_BITS = 3,
  localparam int TW = (N_BITS > 1) ? $clog2(N_BITS) : 1,
  localparam int CW = $clog2(N_BITS * (1 << N_BITS) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadEn,
  input  logic [N_BITS-1:0] loadAddr,
  input  logic [N_BITS-1:0] loadWord,
  input  logic              orderEn,
  input  logic [N_BITS-1:0] orderAddr,
  input  logic [N_BITS-1:0] orderRow,
  input  logic              naturalOrder,
  input  logic              start,
  output logic              gateValid,
  input  logic              gateReady,
  output logic [N_BITS-1:0] gateCtrl,
  output logic [TW-1:0]     gateTarget,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [CW-1:0]     gateCount
);
  rsStrobe_t         strobe;
  logic [N_BITS-1:0] pos;
  logic              rowFixed, isPerm, isIdentity, countAtLimit;

  rs_control #(.N_BITS(N_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .gateReady(gateReady),
    .rowFixed(rowFixed), .isPerm(isPerm), .isIdentity(isIdentity),
    .countAtLimit(countAtLimit), .strobe(strobe), .pos(pos),
    .gateValid(gateValid), .busy(busy), .done(done), .error(error)
  );

  rs_datapath #(.N_BITS(N_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .loadEn(loadEn && !busy), .loadAddr(loadAddr), .loadWord(loadWord),
    .orderEn(orderEn && !busy), .orderAddr(orderAddr), .orderRow(orderRow),
    .naturalOrder(naturalOrder), .strobe(strobe), .pos(pos),
    .rowFixed(rowFixed), .isPerm(isPerm), .isIdentity(isIdentity),
    .countAtLimit(countAtLimit), .gateCtrl(gateCtrl), .gateTarget(gateTarget),
    .gateCount(gateCount)
  );

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int N_BITS = 3,
  localparam int TW    = (N_BITS > 1) ? $clog2(N_BITS) : 1,
  localparam int LIMIT = N_BITS * (1 << N_BITS),
  localparam int CW    = $clog2(LIMIT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gateValid,
  input logic              gateReady,
  input logic [N_BITS-1:0] gateCtrl,
  input logic [TW-1:0]     gateTarget,
  input logic              busy,
  input logic              done,
  input logic [CW-1:0]     gateCount
);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gateValid && !gateReady) |=> (gateValid && $stable(gateCtrl) && $stable(gateTarget)));

  assert_target_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gateValid |-> ((gateCtrl & (N_BITS'(1) << gateTarget)) == '0));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gateValid && gateReady) |=> (gateCount == $past(gateCount) + CW'(1)));

  assert_count_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gateCount) <= LIMIT));

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!gateValid && !busy));

endmodule

bind rev_synth_engine rs_checker #(.N_BITS(N_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .gateValid(gateValid), .gateReady(gateReady),
  .gateCtrl(gateCtrl), .gateTarget(gateTarget), .busy(busy), .done(done),
  .gateCount(gateCount)
);

// File: tb/tb_rev_synth_engine.sv
`timescale 1ns/1ps
module tb_rev_synth_engine;
  localparam int N = 3;
  localparam int ROWS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic loadEn = 0, orderEn = 0, naturalOrder = 1, start = 0, gateReady = 0;
  logic [N-1:0] loadAddr = 0, loadWord = 0, orderAddr = 0, orderRow = 0;
  logic gateValid, busy, done, error;
  logic [N-1:0] gateCtrl;
  logic [1:0] gateTarget;
  logic [4:0] gateCount;

  rev_synth_engine #(.N_BITS(N)) dut (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadAddr(loadAddr), .loadWord(loadWord),
    .orderEn(orderEn), .orderAddr(orderAddr), .orderRow(orderRow),
    .naturalOrder(naturalOrder), .start(start), .gateValid(gateValid),
    .gateReady(gateReady), .gateCtrl(gateCtrl), .gateTarget(gateTarget),
    .busy(busy), .done(done), .error(error), .gateCount(gateCount)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  logic [31:0] rng = 32'h1234_5678;
  int loaded[ROWS];
  int ordM[ROWS];
  int m[ROWS];
  int vis[ROWS];
  int firstCtrl, firstTgt;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  task automatic loadTable();
    for (int i = 0; i < ROWS; i++) begin
      @(negedge clk);
      loadEn = 1; loadAddr = N'(i); loadWord = N'(loaded[i]);
    end
    @(negedge clk); loadEn = 0;
  endtask

  task automatic loadOrder();
    for (int i = 0; i < ROWS; i++) begin
      @(negedge clk);
      orderEn = 1; orderAddr = N'(i); orderRow = N'(ordM[i]);
    end
    @(negedge clk); orderEn = 0;
  endtask

  function automatic int prefixLen();
    int k = 0;
    while (k < ROWS && m[vis[k]] == vis[k]) k++;
    return k;
  endfunction

  // run one synthesis, replaying each accepted gate on the bench table
  task automatic runSynth(input bit nat, input bit randReady, output int gates, output bit errOut);
    int cyc = 0;
    bit wasStall = 0;
    int stallC = 0, stallT = 0;
    gates = 0; errOut = 0; firstCtrl = -1; firstTgt = -1;
    for (int i = 0; i < ROWS; i++) begin
      m[i] = loaded[i];
      vis[i] = nat ? i : ordM[i];
    end
    @(negedge clk); naturalOrder = nat; start = 1;
    @(negedge clk); start = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (randReady) begin nextRand(); gateReady = rng[3] | rng[7]; end
      else gateReady = 1;
      #0.1;
      if (wasStall)
        chk(gateValid && int'(gateCtrl) == stallC && int'(gateTarget) == stallT,
            "R7", "stalled record changed", int'(gateCtrl), stallC);
      if (done) break;
      if (cyc > 3000) begin
        chk(0, "R6", "run did not finish", cyc, 3000);
        break;
      end
      if (gateValid && gateReady) begin
        int c = int'(gateCtrl), t = int'(gateTarget), tm, k, r, w, up, dn, k2;
        bit ok;
        tm = 1 << t;
        if (gates == 0) begin firstCtrl = c; firstTgt = t; end
        chk((c & tm) == 0, "R2", "target inside control mask", c, c & ~tm);
        k = prefixLen();
        r = (k < ROWS) ? vis[k] : 0;
        w = m[r];
        up = r & ~w & 7; dn = w & ~r & 7;
        if (up != 0) ok = ((up & tm) != 0) && ((up & (tm - 1)) == 0) && (c == (w & ~tm));
        else ok = ((dn & tm) != 0) && ((dn & (tm - 1)) == 0) && (c == r);
        chk(ok, "R4", "gate choice for current row (ctrl)", c, (up != 0) ? (w & ~tm) : r);
        for (int j = 0; j < ROWS; j++) if ((m[j] & c) == c) m[j] = m[j] ^ tm;
        k2 = prefixLen();
        chk(k2 >= k, "R3", "corrected prefix shrank", k2, k);
        gates++;
      end
      wasStall = gateValid && !gateReady;
      stallC = int'(gateCtrl); stallT = int'(gateTarget);
    end
    errOut = error;
    chk(!busy, "R6", "busy at done", int'(busy), 0);
    chk(int'(gateCount) == gates, "R6", "gate count vs accepted", int'(gateCount), gates);
    chk(int'(gateCount) <= N * ROWS, "R10", "gate count over budget", int'(gateCount), N * ROWS);
  endtask

  function automatic bit modelIdentity();
    for (int i = 0; i < ROWS; i++) if (m[i] != i) return 0;
    return 1;
  endfunction

  task automatic setMmdsn();
    int o[ROWS] = '{0, 4, 2, 1, 6, 5, 3, 7};
    for (int i = 0; i < ROWS; i++) ordM[i] = o[i];
  endtask

  task automatic setExample();
    int e[ROWS] = '{0, 4, 5, 1, 6, 2, 3, 7};
    for (int i = 0; i < ROWS; i++) loaded[i] = e[i];
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R6 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int g;
    bit e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !error && !gateValid, "R1", "status after reset",
        {busy, done, error, gateValid}, 0);
    chk(gateCount == 0, "R1", "count after reset", int'(gateCount), 0);

    // R5: worked example, natural order; R8: garbage stored order ignored
    for (int i = 0; i < ROWS; i++) ordM[i] = 0;
    loadOrder();
    setExample(); loadTable();
    runSynth(1, 1, g, e);
    chk(firstCtrl == 4 && firstTgt == 0, "R5", "first gate ctrl*4+tgt", firstCtrl * 4 + firstTgt, 16);
    chk(g == 6, "R5", "example gate total", g, 6);
    chk(modelIdentity() && !e, "R8", "natural order ignores stored order", int'(e), 0);

    // R6: restart on the now-identity table emits nothing
    for (int i = 0; i < ROWS; i++) loaded[i] = i;
    runSynth(1, 0, g, e);
    chk(g == 0 && !e, "R6", "restart gates", g, 0);

    // R5: identity table loaded explicitly, every row skipped
    loadTable();
    runSynth(0, 0, g, e);
    chk(g == 0 && !e && done, "R5", "identity table gates", g, 0);

    // R9: non-permutation table
    setExample(); loaded[3] = 4; loadTable();
    runSynth(1, 0, g, e);
    chk(g == 0, "R9", "gates on bad table", g, 0);
    chk(e && done, "R9", "error on bad table", int'(e), 1);

    // R8: popcount-banded order on the example
    setMmdsn(); loadOrder();
    setExample(); loadTable();
    runSynth(0, 1, g, e);
    chk(modelIdentity(), "R8", "banded order converges", 0, 1);
    chk(!e, "R8", "banded order error flag", int'(e), 0);

    // sweep of generated permutations in both orders
    for (int p = 0; p < 120; p++) begin
      for (int i = 0; i < ROWS; i++) loaded[i] = i;
      for (int i = ROWS - 1; i > 0; i--) begin
        int j, tmp;
        nextRand();
        j = int'(rng % (i + 1));
        tmp = loaded[i]; loaded[i] = loaded[j]; loaded[j] = tmp;
      end
      loadTable();
      runSynth(p[0], 1, g, e);
      chk(modelIdentity(), "R6", "gates do not realize identity", p, 1);
      chk(!e, "R10", "error flag on valid run", int'(e), 0);
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule